// File: doc/BRIEF.md
# Selective Harmonic Phasor Extractor

This block produces complex phasors for the voltage and the current of one chosen mains phase at the fundamental and at three harmonic orders set by the user. It avoids a full transform: each bin is a single-frequency DFT term updated recursively, one sample at a time, so fresh values exist after every sample. The bin frequency follows the tracked fundamental. The caller supplies the running fundamental phase and its per-sample step, and each bin rotates at the harmonic order times that phase.

One multiply-accumulate datapath is shared in time. An accepted sample launches sixteen MAC steps: four bins, each with a voltage and a current signal, each with a real and an imaginary part. The block then holds all sixteen accumulators on a result stream until the consumer takes them. Input and output are valid/ready streams. A sample is taken only while the block is idle. While a result waits on a low `out_ready`, `in_ready` stays low, so back-pressure on the output stalls the input. Each accumulator leaks by a factor of (1 − 2^-LEAK) per sample. This bounds leakage when the frequency drifts. A bin whose order changes starts again from zero and reports settled only after a run of samples.

Top module: `harm_phasor_xtr`

## Requirements
- R1: `in_ready` is high only while the block is idle; a sample (all six channel values, `fund_phase`, `fund_step`, `phase_sel`, the three orders) is captured on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle that follows.
- R2: `out_valid` rises exactly 16 clock edges after the edge that accepted the sample.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_phasors` and `out_ok` hold steady and no sample is accepted; the edge with `out_ready` high ends the result and returns the block to idle.
- R4: `phase_sel` picks the channels: 1 picks B, 2 picks C, 0 and 3 pick A.
- R5: Bin 0 has order 1; bins 1..3 take `h1_order`..`h3_order`. A bin's table index is bits [7:2] of (order × `fund_phase`) mod 256. The table gives sin = round(16384·sin(2π·idx/64)) and cos = the sin at (idx+16) mod 64.
- R6: Per sample and signal x, real R ← R − (R>>>LEAK) + ((x·cos)>>>14), imaginary I ← I − (I>>>LEAK) − ((x·sin)>>>14). The shifts are arithmetic (floor), and LEAK is 4 by default.
- R7: `out_phasors` holds 16 AW-bit slots; slot s = 4·bin + 2·signal + part (signal 0 voltage, 1 current; part 0 real, 1 imaginary) sits at bits [s·AW +: AW].
- R8: A harmonic bin whose order is 0 or 1 is invalid: its four slots read zero and its `out_ok` bit is low.
- R9: A bin whose order × `fund_step` is 128 or more (at or above half the sample rate) is invalid in the same way, including bin 0.
- R10: A change of `phase_sel` restarts all four bins from zero for that sample. A change of one order restarts only that bin. Other bins keep accumulating.
- R11: `out_ok[b]` is high only with `out_valid`, only for a valid bin, and only once the bin has processed at least SETTLE (8) samples since its last restart, counting the current one.
- R12: After reset `in_ready` is 1, `out_valid` and `out_ok` are 0 and all accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready |
| v_a | input | XW | Phase A voltage sample, signed |
| v_b | input | XW | Phase B voltage sample, signed |
| v_c | input | XW | Phase C voltage sample, signed |
| i_a | input | XW | Phase A current sample, signed |
| i_b | input | XW | Phase B current sample, signed |
| i_c | input | XW | Phase C current sample, signed |
| fund_phase | input | PW | Tracked fundamental phase, full turn = 2^PW |
| fund_step | input | PW | Fundamental phase advance per sample |
| phase_sel | input | 2 | Phase choice |
| h1_order | input | OW | Harmonic order of bin 1 |
| h2_order | input | OW | Harmonic order of bin 2 |
| h3_order | input | OW | Harmonic order of bin 3 |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_phasors | output | 16·AW | Sixteen signed accumulator slots |
| out_ok | output | 4 | Per-bin settled and valid flags |

## Verification
Each result is due 16 edges after its sample's accept edge: one edge per MAC slot, with no extra register after the last one. The bench records the cycle count just after the accept edge. The monitor reads the outputs at falling edges and checks that `out_valid` first shows up exactly 16 counts later. Stalled results are read again on each of several falling edges while `out_ready` is held low. After the release edge, `out_valid` must be low at the next falling edge.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  localparam int TBITS = 6;   // table index width, 64 points per turn
  localparam int FRAC  = 14;  // coefficient fraction bits

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OUT} hpe_state_e;

  // quarter-wave magnitude, round(16384*sin(2*pi*q/64)), q = 0..16
  function automatic logic signed [15:0] qmag(input logic [4:0] q);
    case (q)
      5'd0:  qmag = 16'sd0;
      5'd1:  qmag = 16'sd1606;
      5'd2:  qmag = 16'sd3196;
      5'd3:  qmag = 16'sd4756;
      5'd4:  qmag = 16'sd6270;
      5'd5:  qmag = 16'sd7723;
      5'd6:  qmag = 16'sd9102;
      5'd7:  qmag = 16'sd10394;
      5'd8:  qmag = 16'sd11585;
      5'd9:  qmag = 16'sd12665;
      5'd10: qmag = 16'sd13623;
      5'd11: qmag = 16'sd14449;
      5'd12: qmag = 16'sd15137;
      5'd13: qmag = 16'sd15679;
      5'd14: qmag = 16'sd16069;
      5'd15: qmag = 16'sd16305;
      5'd16: qmag = 16'sd16384;
      default: qmag = 16'sd0;
    endcase
  endfunction

  // full-turn sine from the quarter table
  function automatic logic signed [15:0] wave(input logic [TBITS-1:0] idx);
    logic signed [15:0] m;
    m = idx[4] ? qmag(5'd16 - {1'b0, idx[3:0]}) : qmag({1'b0, idx[3:0]});
    wave = idx[5] ? -m : m;
  endfunction
endpackage

// File: rtl/hpe_trig.sv
module hpe_trig
  import hpe_pkg::*;
(
  input  logic [TBITS-1:0]   idx,
  output logic signed [15:0] sin_o,
  output logic signed [15:0] cos_o
);
  localparam logic [TBITS-1:0] QTR = TBITS'(1 << (TBITS - 2));

  assign sin_o = wave(idx);
  assign cos_o = wave(idx + QTR);
endmodule

// File: rtl/hpe_mac.sv
module hpe_mac #(
  parameter int XW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 32,
  parameter int LEAK = 4,
  parameter int FR   = 14
) (
  input  logic signed [AW-1:0] base,
  input  logic signed [XW-1:0] x,
  input  logic signed [CW-1:0] coef,
  input  logic                 sub,
  output logic signed [AW-1:0] nxt
);
  localparam int PRW = XW + CW;

  logic signed [PRW-1:0] prod;
  logic signed [PRW-1:0] scl;
  logic signed [AW-1:0]  term;

  assign prod = x * coef;
  assign scl  = prod >>> FR;
  assign term = sub ? -AW'(scl) : AW'(scl);
  assign nxt  = base - (base >>> LEAK) + term;
endmodule

// File: rtl/harm_phasor_xtr.sv
module harm_phasor_xtr #(
  parameter int XW     = 16,
  parameter int PW     = 8,
  parameter int OW     = 6,
  parameter int AW     = 32,
  parameter int LEAK   = 4,
  parameter int SETTLE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [XW-1:0]        v_a,
  input  logic [XW-1:0]        v_b,
  input  logic [XW-1:0]        v_c,
  input  logic [XW-1:0]        i_a,
  input  logic [XW-1:0]        i_b,
  input  logic [XW-1:0]        i_c,
  input  logic [PW-1:0]        fund_phase,
  input  logic [PW-1:0]        fund_step,
  input  logic [1:0]           phase_sel,
  input  logic [OW-1:0]        h1_order,
  input  logic [OW-1:0]        h2_order,
  input  logic [OW-1:0]        h3_order,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [16*AW-1:0]     out_phasors,
  output logic [3:0]           out_ok
);
  import hpe_pkg::*;

  localparam int NB    = 4;
  localparam int NSLOT = NB * 4;
  localparam int SW    = $clog2(NSLOT);
  localparam int STW   = $clog2(SETTLE + 1);
  localparam int MW    = OW + PW;

  hpe_state_e st;
  logic [SW-1:0]         slot;
  logic signed [XW-1:0]  xv_q, xi_q;
  logic [PW-1:0]         ph_q;
  logic [1:0]            sel_q;
  logic [OW-1:0]         ord_q  [NB];
  logic [STW-1:0]        sttl_q [NB];
  logic [NB-1:0]         vld_q, clr_q;
  logic signed [AW-1:0]  acc_q  [NSLOT];

  logic [OW-1:0]         ord_in [NB];
  logic [NB-1:0]         vld_d, clr_d;
  logic [XW-1:0]         xv_d, xi_d;
  logic                  accept;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_OUT);
  assign accept    = in_valid && in_ready;

  assign ord_in[0] = OW'(1);
  assign ord_in[1] = h1_order;
  assign ord_in[2] = h2_order;
  assign ord_in[3] = h3_order;

  always_comb begin
    case (phase_sel)
      2'd1:    begin xv_d = v_b; xi_d = i_b; end
      2'd2:    begin xv_d = v_c; xi_d = i_c; end
      default: begin xv_d = v_a; xi_d = i_a; end
    endcase
  end

  // per-bin validity and restart decisions, taken at accept
  for (genvar b = 0; b < NB; b++) begin : g_bin
    logic [MW-1:0] span;
    logic          order_ok;
    assign span = MW'(ord_in[b]) * MW'(fund_step);
    if (b == 0) begin : g_fund
      assign order_ok = 1'b1;
    end else begin : g_harm
      assign order_ok = (ord_in[b] >= OW'(2));
    end
    assign vld_d[b] = order_ok && (span < MW'(1 << (PW - 1)));
    assign clr_d[b] = (phase_sel != sel_q) || (ord_in[b] != ord_q[b]);
    assign out_ok[b] = out_valid && vld_q[b] && (sttl_q[b] >= STW'(SETTLE));
  end

  // shared datapath: one slot per cycle
  logic [1:0]            cb;
  logic [MW-1:0]         ang;
  logic [TBITS-1:0]      tidx;
  logic signed [15:0]    s_w, c_w;
  logic signed [15:0]    coef;
  logic signed [XW-1:0]  xsel;
  logic signed [AW-1:0]  base, nxt;

  assign cb   = slot[SW-1:2];
  assign ang  = MW'(ord_q[cb]) * MW'(ph_q);
  assign tidx = ang[PW-1:PW-TBITS];
  assign coef = slot[0] ? s_w : c_w;
  assign xsel = slot[1] ? xi_q : xv_q;
  assign base = clr_q[cb] ? '0 : acc_q[slot];

  hpe_trig u_trig (.idx(tidx), .sin_o(s_w), .cos_o(c_w));

  hpe_mac #(.XW(XW), .CW(16), .AW(AW), .LEAK(LEAK), .FR(FRAC)) u_mac (
    .base(base), .x(xsel), .coef(coef), .sub(slot[0]), .nxt(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      slot  <= '0;
      xv_q  <= '0;
      xi_q  <= '0;
      ph_q  <= '0;
      sel_q <= '0;
      vld_q <= '0;
      clr_q <= '0;
      for (int b = 0; b < NB; b++) begin
        ord_q[b]  <= '0;
        sttl_q[b] <= '0;
      end
      for (int s = 0; s < NSLOT; s++) acc_q[s] <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          xv_q  <= xv_d;
          xi_q  <= xi_d;
          ph_q  <= fund_phase;
          sel_q <= phase_sel;
          vld_q <= vld_d;
          clr_q <= clr_d;
          for (int b = 0; b < NB; b++) begin
            ord_q[b] <= ord_in[b];
            if (clr_d[b]) sttl_q[b] <= '0;
          end
          slot <= '0;
          st   <= ST_RUN;
        end
        ST_RUN: begin
          acc_q[slot] <= nxt;
          slot        <= slot + SW'(1);
          if (slot == SW'(NSLOT - 1)) begin
            st <= ST_OUT;
            for (int b = 0; b < NB; b++)
              if (sttl_q[b] != STW'(SETTLE)) sttl_q[b] <= sttl_q[b] + STW'(1);
          end
        end
        ST_OUT: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_out
    assign out_phasors[s*AW +: AW] = vld_q[s/4] ? acc_q[s] : '0;
  end
endmodule

// File: rtl/hpe_checker.sv
module hpe_checker #(
  parameter int AW     = 32,
  parameter int SETTLE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [16*AW-1:0] out_phasors,
  input logic [3:0]       out_ok,
  input logic [1:0]       phase_sel
);
  localparam int NSLOT = 16;

  int unsigned lat;
  int unsigned sel_run;
  logic [1:0]  sel_last;
  logic        acc_w;

  assign acc_w = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat      <= 0;
      sel_run  <= 0;
      sel_last <= '0;
    end else begin
      if (acc_w) lat <= 0;
      else if (lat < 1000) lat <= lat + 1;
      if (acc_w) begin
        sel_last <= phase_sel;
        if (phase_sel != sel_last) sel_run <= 1;
        else if (sel_run < 1000) sel_run <= sel_run + 1;
      end
    end
  end

  // R1: an accepted sample makes the block busy
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> !in_ready);

  // R2: result appears a fixed number of edges after acceptance
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == NSLOT));

  // R3: stalled result holds
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phasors) && $stable(out_ok)));

  // R11: fundamental bin settles only after enough samples on one phase
  p_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok[0]) |-> (sel_run >= SETTLE));

  // R11: no settled flag without a result
  p_ok_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_ok == 4'b0000));
endmodule

bind harm_phasor_xtr hpe_checker #(.AW(AW), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_phasors(out_phasors),
  .out_ok(out_ok), .phase_sel(phase_sel)
);

// File: tb/sim_harm_phasor_xtr.sv
module sim_harm_phasor_xtr;
  localparam int XW = 16, PW = 8, OW = 6, AW = 32, LEAK = 4, SETTLE = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [XW-1:0] v_a, v_b, v_c, i_a, i_b, i_c;
  logic [PW-1:0] fund_phase, fund_step;
  logic [1:0]    phase_sel;
  logic [OW-1:0] h1_order, h2_order, h3_order;
  logic [16*AW-1:0] out_phasors;
  logic [3:0]    out_ok;

  harm_phasor_xtr #(.XW(XW), .PW(PW), .OW(OW), .AW(AW), .LEAK(LEAK), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .v_a(v_a), .v_b(v_b), .v_c(v_c), .i_a(i_a), .i_b(i_b), .i_c(i_c),
    .fund_phase(fund_phase), .fund_step(fund_step), .phase_sel(phase_sel),
    .h1_order(h1_order), .h2_order(h2_order), .h3_order(h3_order),
    .out_valid(out_valid), .out_ready(out_ready), .out_phasors(out_phasors), .out_ok(out_ok)
  );

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    longint     slot [16];
    logic [3:0] ok;
    string      tag;
    longint     acc_c;
    int         stall;
  } exp_t;
  exp_t sb [$];

  longint m_acc [16];
  int m_sel = 0;
  int m_ord [4] = '{0, 0, 0, 0};
  int m_n   [4] = '{0, 0, 0, 0};
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint tsin(input int idx);
    real r;
    r = 16384.0 * $sin(2.0 * 3.14159265358979 * idx / 64.0);
    return (r >= 0.0) ? longint'($rtoi(r + 0.5)) : -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic int gen(input int n, input int k);
    return ((n * 7919 + k * 104729) % 20001) - 10000;
  endfunction

  task automatic send(input int sel, input int h1, input int h2, input int h3,
                      input int ph, input int stp, input int n,
                      input string tag, input int stall);
    exp_t e;
    int vs [3], is [3];
    int ords [4];
    longint xs [2];
    for (int p = 0; p < 3; p++) begin
      vs[p] = gen(n, p);
      is[p] = gen(n, p + 3);
    end
    ords = '{1, h1, h2, h3};
    xs[0] = (sel == 1) ? vs[1] : (sel == 2) ? vs[2] : vs[0];
    xs[1] = (sel == 1) ? is[1] : (sel == 2) ? is[2] : is[0];
    for (int b = 0; b < 4; b++) begin
      int h, idx;
      bit vld, clr;
      longint c, s;
      h   = ords[b];
      vld = (b == 0 || h >= 2) && (h * stp < 128);
      clr = (sel != m_sel) || (h != m_ord[b]);
      idx = ((h * ph) % 256) >> 2;
      c = tsin((idx + 16) % 64);
      s = tsin(idx);
      for (int g = 0; g < 2; g++) begin
        int sr;
        longint bre, bim;
        sr  = b * 4 + g * 2;
        bre = clr ? 0 : m_acc[sr];
        bim = clr ? 0 : m_acc[sr + 1];
        m_acc[sr]     = bre - (bre >>> LEAK) + ((xs[g] * c) >>> 14);
        m_acc[sr + 1] = bim - (bim >>> LEAK) - ((xs[g] * s) >>> 14);
        e.slot[sr]     = vld ? m_acc[sr] : 0;
        e.slot[sr + 1] = vld ? m_acc[sr + 1] : 0;
      end
      m_n[b] = clr ? 1 : ((m_n[b] + 1 > SETTLE) ? SETTLE : m_n[b] + 1);
      e.ok[b] = vld && (m_n[b] >= SETTLE);
      m_ord[b] = h;
    end
    m_sel   = sel;
    e.tag   = tag;
    e.stall = stall;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    v_a = XW'(vs[0]); v_b = XW'(vs[1]); v_c = XW'(vs[2]);
    i_a = XW'(is[0]); i_b = XW'(is[1]); i_c = XW'(is[2]);
    phase_sel = 2'(sel);
    h1_order = OW'(h1); h2_order = OW'(h2); h3_order = OW'(h3);
    fund_phase = PW'(ph); fund_step = PW'(stp);
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    e.acc_c = cyc;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1", "in_ready after accept", longint'(in_ready), 0);
  endtask

  // monitor / scoreboard
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          logic [16*AW-1:0] held;
          e = sb.pop_front();
          chk(cyc - e.acc_c == 16, "R2", "latency", cyc - e.acc_c, 16);
          for (int s = 0; s < 16; s++) begin
            longint a;
            a = longint'($signed(out_phasors[s*AW +: AW]));
            chk(a == e.slot[s], e.tag, $sformatf("slot %0d", s), a, e.slot[s]);
          end
          for (int b = 0; b < 4; b++)
            chk(out_ok[b] == e.ok[b], "R11", $sformatf("out_ok[%0d] (%s)", b, e.tag),
                longint'(out_ok[b]), longint'(e.ok[b]));
          held = out_phasors;
          for (int k = 0; k < e.stall; k++) begin
            @(negedge clk);
            chk(out_valid && !in_ready && out_phasors == held, "R3", "stalled hold",
                longint'(out_valid), 1);
          end
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          chk(out_valid == 1'b0, "R3", "release", longint'(out_valid), 0);
        end
      end
    end
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ph, n;
    for (int s = 0; s < 16; s++) m_acc[s] = 0;
    rst_n = 1'b0; in_valid = 1'b0;
    v_a = '0; v_b = '0; v_c = '0; i_a = '0; i_b = '0; i_c = '0;
    fund_phase = '0; fund_step = '0; phase_sel = '0;
    h1_order = '0; h2_order = '0; h3_order = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", longint'(out_valid), 0);
    chk(out_ok == 4'b0, "R12", "out_ok after reset", longint'(out_ok), 0);
    ph = 0; n = 0;
    // main function: phase A, orders 2,3,5, settling
    for (int k = 0; k < 12; k++) begin
      send(0, 2, 3, 5, ph, 9, n, "R5 R6 R7", 0); ph = (ph + 9) % 256; n++;
    end
    // R10: one order changes, others keep going
    for (int k = 0; k < 3; k++) begin
      send(0, 2, 7, 5, ph, 9, n, "R10", 0); ph = (ph + 9) % 256; n++;
    end
    // R4: each phase choice
    for (int sel = 1; sel < 4; sel++)
      for (int k = 0; k < 3; k++) begin
        send(sel, 2, 7, 5, ph, 11, n, "R4", 0); ph = (ph + 11) % 256; n++;
      end
    // R8: orders 0 and 1 invalid
    for (int k = 0; k < 2; k++) begin
      send(3, 0, 1, 4, ph, 11, n, "R8", 0); ph = (ph + 11) % 256; n++;
    end
    // R9: orders at or beyond half the sample rate
    for (int k = 0; k < 3; k++) begin
      send(3, 3, 4, 2, ph, 40, n, "R9", 0); ph = (ph + 40) % 256; n++;
    end
    send(3, 3, 4, 2, ph, 130, n, "R9", 0); ph = (ph + 130) % 256; n++;
    // R3: back-pressure
    for (int k = 0; k < 3; k++) begin
      send(2, 6, 13, 63, ph, 2, n, "R3", 3 + k); ph = (ph + 2) % 256; n++;
    end
    while (sb.size() != 0 || !in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule